// File: doc/BRIEF.md
# PHY Control Register Access Engine

This block is a hardware master that reads and writes the internal control registers of a PHY through an indirect, capture-style port. A requester hands it one operation at a time: a read or write flag, a 16-bit PHY register address and, for writes, 16 bits of data. The engine then runs the access as a chain of handshakes. In each step it puts a value on the shared data-in bus and pulses one of four strobes: capture address, capture data, read or write. The PHY answers each strobe with a pending flag, which stays set until the PHY has taken the request. The engine polls that flag. If the flag is still set, it waits a parameterised gap and polls again. The number of polls per step is limited.

A write runs three steps: capture address, capture data, then write. A read captures the address and then runs the read step twice, because the PHY can return a stale value on the first read after an address capture. The engine drops the first result and returns the value on the data-out bus as it stands once the second read step has cleared. If any step exhausts its polls, the access is abandoned at that point. The engine then reports completion and the error flag together, with zero read data.

Typical targets are the per-lane override registers of a multi-lane PHY, for example the receiver override word at 0x1006 plus 0x100 per lane and the transmitter drive override word at 0x1002 plus 0x100 per lane. The engine treats addresses as opaque.

Top module: `phy_creg_engine`

## Requirements
- R1: After reset, busy, done, error, all four strobes and rdata are low.
- R2: A request (req_valid high) is taken only when busy is low. busy rises in the cycle after acceptance and stays high until the cycle in which done is high. A request raised while busy is ignored and causes no strobe.
- R3: Every access begins with a one-cycle stb_addr pulse while cr_din carries the request address. cr_din stays stable while the engine polls for that step.
- R4: A write issues stb_addr, then stb_data with cr_din equal to the write data, then stb_wr. Each strobe is issued only after the pending flag of the previous step reads clear.
- R5: A read issues stb_addr and then exactly two stb_rd pulses. rdata at done is the cr_dout value sampled once the second read step's pending flag reads clear. The value produced by the first read pass is discarded.
- R6: The first poll of a step falls in the cycle after its strobe. Further polls follow every POLL_GAP+1 cycles, with at most POLL_LIMIT (10) polls per step. A flag that first reads clear on the last allowed poll still lets the access succeed.
- R7: If the pending flag is still set on the last allowed poll, the access ends: done and error are high in the same cycle, rdata is zero, and no later strobe of that access is issued. error is never high without done.
- R8: done is a single-cycle pulse. At most one strobe is high in any cycle, and two strobes never occur in consecutive cycles.
- R9: rdata changes only in a cycle where done is high. A write or a failed access leaves rdata at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Poll limit exhausted; valid with done |
| rdata | output | 16 | Read result, valid with done |
| cr_din | output | 16 | Data-in bus to the PHY port |
| stb_addr | output | 1 | Capture-address strobe |
| stb_data | output | 1 | Capture-data strobe |
| stb_rd | output | 1 | Read strobe |
| stb_wr | output | 1 | Write strobe |
| pend_addr | input | 1 | Capture-address latch still set |
| pend_data | input | 1 | Capture-data latch still set |
| pend_rd | input | 1 | Read latch still set |
| pend_wr | input | 1 | Write latch still set |
| cr_dout | input | 16 | Data-out bus from the PHY port |

## Verification
Acceptance happens at the edge where req_valid is seen while idle. The first strobe follows one cycle later, and the first poll one cycle after that. Each later poll of a step is POLL_GAP+1 cycles after the previous one. done therefore rises at the edge that samples a clear flag on the final step. In a timeout it rises at the edge of the tenth poll, so busy is high for exactly 2+9(POLL_GAP+1) cycles in a first-step timeout. The bench drives inputs and samples outputs on the falling edge. It counts busy cycles against these closed-form values, including the success-on-tenth-poll and fail-on-tenth-poll boundary. It reads strobe order and cr_din from a log kept by its PHY model at each rising edge.

// File: rtl/phy_creg_pkg.sv
// Package: shared types and step ordering for the PHY control register engine.
// Assumes: a write walks ADDR->DATA->WR and a read walks ADDR->RD1->RD2.
package phy_creg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRE,
        ST_POLL,
        ST_GAP
    } eng_state_e;

    typedef enum logic [2:0] {
        STEP_ADDR,
        STEP_DATA,
        STEP_WR,
        STEP_RD1,
        STEP_RD2
    } step_e;

    localparam int NUM_STB = 4;
    localparam int KIND_ADDR = 0;
    localparam int KIND_DATA = 1;
    localparam int KIND_RD   = 2;
    localparam int KIND_WR   = 3;

    // Step that follows s for the given operation
    function automatic step_e next_step(input logic is_write, input step_e s);
        case (s)
            STEP_ADDR: next_step = is_write ? STEP_DATA : STEP_RD1;
            STEP_DATA: next_step = STEP_WR;
            STEP_RD1:  next_step = STEP_RD2;
            default:   next_step = STEP_ADDR;
        endcase
    endfunction

    // True for the step that ends an access
    function automatic logic is_final(input step_e s);
        is_final = (s == STEP_WR) || (s == STEP_RD2);
    endfunction

    // Strobe index used by a step
    function automatic int unsigned step_kind(input step_e s);
        case (s)
            STEP_ADDR: step_kind = KIND_ADDR;
            STEP_DATA: step_kind = KIND_DATA;
            STEP_WR:   step_kind = KIND_WR;
            default:   step_kind = KIND_RD;
        endcase
    endfunction

endpackage

// File: rtl/phy_creg_poll.sv
// Poll bookkeeping: counts polls made in the current step and times the gap
// between polls. Assumes POLL_LIMIT >= 1 and POLL_GAP >= 1.
module phy_creg_poll #(
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic polling,
    input  logic waiting,
    input  logic flag_set,
    output logic last_try,
    output logic gap_done
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    logic [PW-1:0] poll_cnt;
    logic [GW-1:0] gap_cnt;

    // Count unsuccessful polls since the step's strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            poll_cnt <= '0;
        else if (arm)
            poll_cnt <= '0;
        else if (polling && flag_set)
            poll_cnt <= poll_cnt + 1'b1;
    end

    // Count cycles spent waiting between polls
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (waiting)
            gap_cnt <= gap_cnt + 1'b1;
        else
            gap_cnt <= '0;
    end

    // Decode the limit and gap end
    always_comb begin
        last_try = (poll_cnt == PW'(POLL_LIMIT - 1));
        gap_done = waiting && (gap_cnt == GW'(POLL_GAP - 1));
    end

endmodule

// File: rtl/phy_creg_strobe.sv
// Strobe decoder: turns the firing step into one of the four PHY strobes.
// Assumes fire is high for exactly one cycle per step.
module phy_creg_strobe
    import phy_creg_pkg::*;
(
    input  logic               fire,
    input  step_e              step,
    output logic [NUM_STB-1:0] stb
);
    for (genvar k = 0; k < NUM_STB; k++) begin : g_stb
        // Raise strobe k when the firing step maps to it
        always_comb stb[k] = fire && (step_kind(step) == k);
    end

endmodule

// File: rtl/phy_creg_engine.sv
// PHY control register access engine. Sequences capture/read/write
// handshakes, polls each self-clearing latch with a bounded retry count,
// repeats every read and keeps only the second result.
// Assumes the PHY raises its pend_* flag no later than the poll that
// follows a strobe, and holds cr_dout steady once a read latch clears.
module phy_creg_engine
    import phy_creg_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [BUS_W-1:0] rdata,
    output logic [BUS_W-1:0] cr_din,
    output logic             stb_addr,
    output logic             stb_data,
    output logic             stb_rd,
    output logic             stb_wr,
    input  logic             pend_addr,
    input  logic             pend_data,
    input  logic             pend_rd,
    input  logic             pend_wr,
    input  logic [BUS_W-1:0] cr_dout
);
    eng_state_e       state_q;
    step_e            step_q;
    step_e            step_nx;
    logic             write_q;
    logic [BUS_W-1:0] addr_q;
    logic [BUS_W-1:0] wdata_q;
    logic [BUS_W-1:0] din_q;
    logic             flag_sel;
    logic             last_try;
    logic             gap_done;
    logic [NUM_STB-1:0] stb_vec;

    // Pick the pending flag belonging to the current step
    always_comb begin
        case (step_q)
            STEP_ADDR: flag_sel = pend_addr;
            STEP_DATA: flag_sel = pend_data;
            STEP_WR:   flag_sel = pend_wr;
            default:   flag_sel = pend_rd;
        endcase
        step_nx = next_step(write_q, step_q);
    end

    phy_creg_poll #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state_q == ST_FIRE),
        .polling  (state_q == ST_POLL),
        .waiting  (state_q == ST_GAP),
        .flag_set (flag_sel),
        .last_try (last_try),
        .gap_done (gap_done)
    );

    phy_creg_strobe u_stb (
        .fire (state_q == ST_FIRE),
        .step (step_q),
        .stb  (stb_vec)
    );

    // Main sequencer: accept, fire, poll, wait, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_ADDR;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            din_q   <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
            rdata   <= '0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        write_q <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        din_q   <= req_addr;
                        step_q  <= STEP_ADDR;
                        state_q <= ST_FIRE;
                    end
                end
                ST_FIRE: state_q <= ST_POLL;
                ST_POLL: begin
                    if (!flag_sel) begin
                        if (is_final(step_q)) begin
                            done    <= 1'b0 | 1'b1;
                            rdata   <= write_q ? '0 : cr_dout;
                            state_q <= ST_IDLE;
                        end else begin
                            step_q  <= step_nx;
                            din_q   <= (step_nx == STEP_DATA) ? wdata_q : addr_q;
                            state_q <= ST_FIRE;
                        end
                    end else if (last_try) begin
                        done    <= 1'b1;
                        error   <= 1'b1;
                        rdata   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_done) state_q <= ST_POLL;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the port-side outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        cr_din   = din_q;
        stb_addr = stb_vec[KIND_ADDR];
        stb_data = stb_vec[KIND_DATA];
        stb_rd   = stb_vec[KIND_RD];
        stb_wr   = stb_vec[KIND_WR];
    end

endmodule

// File: rtl/phy_creg_engine_chk.sv
// Checker for phy_creg_engine: port-level protocol properties, bound below.
module phy_creg_engine_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [BUS_W-1:0] rdata,
    input logic [BUS_W-1:0] cr_din,
    input logic             stb_addr,
    input logic             stb_data,
    input logic             stb_rd,
    input logic             stb_wr
);
    logic any_stb;
    always_comb any_stb = stb_addr | stb_data | stb_rd | stb_wr;

    // R8: strobes are mutually exclusive
    a_r8_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_addr, stb_data, stb_rd, stb_wr}));
    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a poll always separates two strobes
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);
    // R7: error only alongside done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
    // R7: failed access returns zero
    a_r7_err_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (rdata == '0));
    // R2: busy drops only when done arrives
    a_r2_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R3: strobes occur only inside an access
    a_r3_stb_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> busy);
    // R3: cr_din held through the poll after a strobe
    a_r3_din_held: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> $stable(cr_din));
    // R9: rdata moves only with done
    a_r9_rdata_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

endmodule

bind phy_creg_engine phy_creg_engine_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .rdata    (rdata),
    .cr_din   (cr_din),
    .stb_addr (stb_addr),
    .stb_data (stb_data),
    .stb_rd   (stb_rd),
    .stb_wr   (stb_wr)
);

// File: tb/phy_creg_engine_bench.sv
// Directed bench with a small PHY model: per-latch hold counts, a register
// store, and a stale value on the first read after each address capture.
module phy_creg_engine_bench;
    localparam int W   = 16;
    localparam int GAP = 3;
    localparam int LIM = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [W-1:0] req_addr = '0;
    logic [W-1:0] req_wdata = '0;
    logic         busy, done, error;
    logic [W-1:0] rdata, cr_din, cr_dout;
    logic         stb_addr, stb_data, stb_rd, stb_wr;
    logic         pend_addr, pend_data, pend_rd, pend_wr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    phy_creg_engine #(.BUS_W(W), .POLL_LIMIT(LIM), .POLL_GAP(GAP)) u_phy_creg_engine (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .busy, .done, .error, .rdata, .cr_din,
        .stb_addr, .stb_data, .stb_rd, .stb_wr,
        .pend_addr, .pend_data, .pend_rd, .pend_wr, .cr_dout
    );

    // ---------------- PHY model ----------------
    logic [15:0] hold_a = 0, hold_d = 0, hold_r = 0, hold_w = 0;
    logic [15:0] cnt_a, cnt_d, cnt_r, cnt_w;
    logic [W-1:0] a_reg, d_reg, dout_q;
    logic first_rd;
    logic [W-1:0] mem [0:63];
    logic [2:0]  log_k [0:255];
    logic [W-1:0] log_d [0:255];
    logic [7:0]  log_n;

    function automatic logic [5:0] idx(input logic [W-1:0] a);
        idx = {a[9:8], a[3:0]};
    endfunction

    assign pend_addr = (cnt_a != 0);
    assign pend_data = (cnt_d != 0);
    assign pend_rd   = (cnt_r != 0);
    assign pend_wr   = (cnt_w != 0);
    assign cr_dout   = dout_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_a <= 0; cnt_d <= 0; cnt_r <= 0; cnt_w <= 0;
            a_reg <= 0; d_reg <= 0; dout_q <= 0; first_rd <= 0; log_n <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= 16'h0000;
        end else begin
            if (cnt_a != 0) cnt_a <= cnt_a - 1;
            if (cnt_d != 0) cnt_d <= cnt_d - 1;
            if (cnt_r != 0) cnt_r <= cnt_r - 1;
            if (cnt_w != 0) cnt_w <= cnt_w - 1;
            if (stb_addr) begin a_reg <= cr_din; cnt_a <= hold_a; first_rd <= 1'b1; end
            if (stb_data) begin d_reg <= cr_din; cnt_d <= hold_d; end
            if (stb_rd) begin
                cnt_r <= hold_r;
                dout_q <= first_rd ? 16'hBAD0 : mem[idx(a_reg)];
                first_rd <= 1'b0;
            end
            if (stb_wr) begin mem[idx(a_reg)] <= d_reg; cnt_w <= hold_w; end
            if (stb_addr | stb_data | stb_rd | stb_wr) begin
                log_k[log_n] <= stb_addr ? 3'd1 : stb_data ? 3'd2 : stb_rd ? 3'd3 : 3'd4;
                log_d[log_n] <= cr_din;
                log_n <= log_n + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    logic [W-1:0] got_rdata;
    logic         got_err;
    int           got_busy;
    logic [7:0]   base;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic wr, input logic [W-1:0] a, input logic [W-1:0] d);
        int n = 0;
        @(negedge clk);
        base = log_n;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        got_busy = 0;
        while (!done && n < 4000) begin
            if (busy) got_busy++;
            n++;
            @(negedge clk);
        end
        got_rdata = rdata;
        got_err = error;
        chk(done, "R2 access completes", done, 1);
        @(negedge clk);
        chk(!done, "R8 done single cycle", done, 0);
    endtask

    function automatic int nlog();
        nlog = int'(8'(log_n - base));
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!busy && !done && !error, "R1 status low after reset", {busy, done, error}, 0);
        chk(rdata == 0, "R1 rdata zero after reset", rdata, 0);
        chk(!(stb_addr | stb_data | stb_rd | stb_wr), "R1 strobes low", 0, 0);
    endtask

    task automatic t_write_read();
        hold_a = 0; hold_d = 0; hold_r = 0; hold_w = 0;
        run_req(1'b1, 16'h1006, 16'h0B53);
        chk(!got_err, "R4 write no error", got_err, 0);
        chk(got_rdata == 0, "R9 write leaves rdata zero", got_rdata, 0);
        chk(nlog() == 3, "R4 write strobe count", nlog(), 3);
        chk(log_k[base] == 1 && log_d[base] == 16'h1006, "R3 address strobe first", log_d[base], 16'h1006);
        chk(log_k[8'(base+1)] == 2 && log_d[8'(base+1)] == 16'h0B53, "R4 data strobe second", log_d[8'(base+1)], 16'h0B53);
        chk(log_k[8'(base+2)] == 4, "R4 write strobe last", log_k[8'(base+2)], 4);
        chk(got_busy == 6, "R6 write busy cycles", got_busy, 6);
        run_req(1'b1, 16'h1002, 16'h3F7F);
        run_req(1'b0, 16'h1006, 16'h0000);
        chk(!got_err && got_rdata == 16'h0B53, "R5 read returns second pass", got_rdata, 16'h0B53);
        chk(nlog() == 3 && log_k[8'(base+1)] == 3 && log_k[8'(base+2)] == 3, "R5 two read strobes", nlog(), 3);
        run_req(1'b0, 16'h1002, 16'h0000);
        chk(got_rdata == 16'h3F7F, "R5 read second register", got_rdata, 16'h3F7F);
    endtask

    task automatic t_busy_ignore();
        int n = 0;
        hold_a = 8; hold_d = 0; hold_r = 0; hold_w = 0;
        @(negedge clk);
        base = log_n;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1106; req_wdata = 16'h4444;
        @(negedge clk);
        req_addr = 16'h1102; req_wdata = 16'h9999;
        while (!done && n < 4000) begin n++; @(negedge clk); end
        req_valid = 1'b0;
        chk(nlog() == 3 && log_d[base] == 16'h1106, "R2 busy request ignored", nlog(), 3);
        hold_a = 0;
        run_req(1'b0, 16'h1102, 16'h0000);
        chk(got_rdata == 16'h0000, "R2 ignored write had no effect", got_rdata, 0);
        run_req(1'b0, 16'h1106, 16'h0000);
        chk(got_rdata == 16'h4444, "R2 accepted write landed", got_rdata, 16'h4444);
    endtask

    task automatic t_poll_edge();
        hold_a = 36; hold_d = 0; hold_r = 0; hold_w = 0;
        run_req(1'b1, 16'h1206, 16'h1234);
        chk(!got_err, "R6 clear on tenth poll succeeds", got_err, 0);
        chk(got_busy == 42, "R6 poll spacing busy cycles", got_busy, 42);
        hold_a = 37;
        run_req(1'b1, 16'h1206, 16'h5678);
        chk(got_err, "R7 set on tenth poll fails", got_err, 1);
        chk(got_busy == 2 + 9 * (GAP + 1), "R6 timeout busy cycles", got_busy, 2 + 9 * (GAP + 1));
        chk(nlog() == 1, "R7 no strobe after address timeout", nlog(), 1);
        hold_a = 0;
        run_req(1'b0, 16'h1206, 16'h0000);
        chk(got_rdata == 16'h1234, "R7 failed write left register", got_rdata, 16'h1234);
    endtask

    task automatic t_timeouts();
        hold_a = 0; hold_d = 16'hFFFF; hold_r = 0; hold_w = 0;
        run_req(1'b1, 16'h1006, 16'hAAAA);
        chk(got_err && got_rdata == 0, "R7 data step timeout", got_err, 1);
        chk(nlog() == 2 && log_k[8'(base+1)] == 2, "R7 write strobe skipped", nlog(), 2);
        hold_d = 0; hold_r = 16'hFFFF;
        run_req(1'b0, 16'h1006, 16'h0000);
        chk(got_err && got_rdata == 0, "R7 read timeout returns zero", got_rdata, 0);
        chk(nlog() == 2, "R7 second read skipped", nlog(), 2);
        hold_r = 5;
        run_req(1'b0, 16'h1006, 16'h0000);
        chk(!got_err && got_rdata == 16'h0B53, "R5 slow read latch", got_rdata, 16'h0B53);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_busy_ignore();
        t_poll_edge();
        t_timeouts();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule